// File: doc/BRIEF.md
# Virtual Address TLB Matcher

This block is the lookup stage of a small, fully associative translation buffer. For each request it forms a 41-bit virtual address from three parts: a 32-bit effective address, one address-space bit and an 8-bit process identifier. It then compares that address against all eight entries at the same time. The access kind decides where the space bit and the process identifier come from. A fetch uses the instruction-space state bit. A data access or any cache maintenance operation uses the data-space state bit. Both of these kinds take the process identifier from the process ID register. A software-driven search uses neither: it takes both the identifier and the space bit from fields of a search-control register.

The comparison itself is combinational. The result is registered, so hit, index and multi-hit appear one cycle after the request, qualified by a response strobe. Each entry has its own page-size code, which sets how many low address bits are left out of the page-number compare. A single write port loads or invalidates one entry per cycle. Mapping to real addresses, access permissions and victim choice are not part of this block.

Top module: `vtlb_matcher`

## Requirements
- R1: After reset every entry is invalid and `hit`, `multiHit`, `rspValid` and `hitIdx` are 0; a lookup made right after reset misses.
- R2: `rspValid` is 1 exactly in the cycle after a cycle with `reqValid`=1. When `rspValid` is 0, `hit`, `multiHit` and `hitIdx` are 0.
- R3: `reqKind`=0 (fetch) compares the entry space field with `instSpace` and the entry ID with `procId`.
- R4: `reqKind`=1 (data or cache maintenance) and `reqKind`=3 both compare the entry space field with `dataSpace` and the entry ID with `procId`.
- R5: `reqKind`=2 (software search) uses `srchSpace` and `srchPid`. For this kind, `instSpace`, `dataSpace` and `procId` have no effect.
- R6: An entry whose ID field is 0 matches any process identifier.
- R7: Size codes 0..7 select pages of 1K, 4K, 16K, 64K, 256K, 1M, 16M and 256M. The entry page number (`wrEpn`, aligned to `effAddr[31:10]`) is compared only on the address bits above the page offset.
- R8: An invalid entry never matches. On a miss, `hit`=0 and `hitIdx`=0.
- R9: When two or more entries match, `hit`=1, `multiHit`=1 and `hitIdx` is the lowest matching index. With exactly one match, `multiHit`=0.
- R10: A write with `wrEn`=1 changes entry `wrIdx` at the clock edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqKind | input | 2 | 0 fetch, 1 data/cache op, 2 software search, 3 as data |
| effAddr | input | 32 | Effective address |
| instSpace | input | 1 | Instruction-space state bit |
| dataSpace | input | 1 | Data-space state bit |
| procId | input | 8 | Process ID register |
| srchPid | input | 8 | Search-control process ID field |
| srchSpace | input | 1 | Search-control space field |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 3 | Entry to write |
| wrValid | input | 1 | Valid bit to write |
| wrEpn | input | 22 | Page number, aligned to effAddr[31:10] |
| wrSpace | input | 1 | Translation space field |
| wrTid | input | 8 | Translation ID (0 = any) |
| wrSize | input | 3 | Page size code |
| hit | output | 1 | At least one entry matched |
| hitIdx | output | 3 | Lowest matching index |
| multiHit | output | 1 | More than one entry matched |
| rspValid | output | 1 | Result strobe, one cycle after request |

## Verification
The hardest cases to reach from the ports are overlapping matches and a write that races a lookup. A multi-hit needs two valid entries of different page sizes whose ranges nest, plus an address that falls inside both. The bench loads a 256M page and a 16M page inside it, then probes an address they share. The race case drives a write and a lookup in the same cycle and checks that the lookup misses, then repeats the lookup one cycle later and checks that it hits.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int EA_W     = 32;
  localparam int PID_W    = 8;
  localparam int PAGE_LSB = 10;
  localparam int EPN_W    = EA_W - PAGE_LSB;
  localparam int SIZE_W   = 3;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_SEARCH = 2'd2,
    KIND_RSVD   = 2'd3
  } access_kind_e;

  typedef struct packed {
    logic              valid;
    logic              space;
    logic [PID_W-1:0]  tid;
    logic [SIZE_W-1:0] size;
    logic [EPN_W-1:0]  epn;
  } tlb_entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             lookup;
    logic             write;
    logic             space;
    logic [PID_W-1:0] pid;
    logic [EA_W-1:0]  ea;
  } ctrl_strobe_t;

  // bits of the page number left in the compare for a size code
  function automatic logic [EPN_W-1:0] sizeMask(input logic [SIZE_W-1:0] code);
    int sh;
    case (code)
      3'd0: sh = 0;
      3'd1: sh = 2;
      3'd2: sh = 4;
      3'd3: sh = 6;
      3'd4: sh = 8;
      3'd5: sh = 10;
      3'd6: sh = 14;
      default: sh = 18;
    endcase
    return ~((EPN_W'(1) << sh) - EPN_W'(1));
  endfunction
endpackage

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
(
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [EA_W-1:0]  effAddr,
  input  logic             instSpace,
  input  logic             dataSpace,
  input  logic [PID_W-1:0] procId,
  input  logic [PID_W-1:0] srchPid,
  input  logic             srchSpace,
  input  logic             wrEn,
  output ctrl_strobe_t     strobes
);
  access_kind_e kind;
  assign kind = access_kind_e'(reqKind);

  always_comb begin
    strobes.lookup = reqValid;
    strobes.write  = wrEn;
    strobes.ea     = effAddr;
    unique case (kind)
      KIND_FETCH: begin
        strobes.space = instSpace;
        strobes.pid   = procId;
      end
      KIND_SEARCH: begin
        strobes.space = srchSpace;
        strobes.pid   = srchPid;
      end
      default: begin
        strobes.space = dataSpace;
        strobes.pid   = procId;
      end
    endcase
  end
endmodule

// File: rtl/vtlb_datapath.sv
module vtlb_datapath
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  tlb_entry_t       wrEntry,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic             multiHit,
  output logic             rspValid
);
  tlb_entry_t             ents [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       firstIdx;
  logic [EPN_W-1:0]       reqEpn;

  assign reqEpn = strobes.ea[EA_W-1:PAGE_LSB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
    end else if (strobes.write) begin
      ents[wrIdx] <= wrEntry;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    logic [EPN_W-1:0] pageMask;
    logic epnOk, tidOk, spaceOk;
    assign pageMask = sizeMask(ents[i].size);
    assign epnOk    = ((ents[i].epn ^ reqEpn) & pageMask) == '0;
    assign tidOk    = (ents[i].tid == '0) || (ents[i].tid == strobes.pid);
    assign spaceOk  = ents[i].space == strobes.space;
    assign matchVec[i] = ents[i].valid && epnOk && tidOk && spaceOk;
  end

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) firstIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      hit      <= 1'b0;
      hitIdx   <= '0;
      multiHit <= 1'b0;
    end else begin
      rspValid <= strobes.lookup;
      hit      <= strobes.lookup && (|matchVec);
      hitIdx   <= strobes.lookup ? firstIdx : '0;
      multiHit <= strobes.lookup && ($countones(matchVec) > 1);
    end
  end

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookup |=> rspValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!hit && !multiHit && hitIdx == '0));
  p_multi_implies_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit);
  p_miss_idx_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> hitIdx == '0);
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.write |=> ents[$past(wrIdx)] == $past(wrEntry));
endmodule

// File: rtl/vtlb_matcher.sv
module vtlb_matcher
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [EA_W-1:0]      effAddr,
  input  logic                 instSpace,
  input  logic                 dataSpace,
  input  logic [PID_W-1:0]     procId,
  input  logic [PID_W-1:0]     srchPid,
  input  logic                 srchSpace,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 wrValid,
  input  logic [EPN_W-1:0]     wrEpn,
  input  logic                 wrSpace,
  input  logic [PID_W-1:0]     wrTid,
  input  logic [SIZE_W-1:0]    wrSize,
  output logic                 hit,
  output logic [IDX_W-1:0]     hitIdx,
  output logic                 multiHit,
  output logic                 rspValid
);
  ctrl_strobe_t strobes;
  tlb_entry_t   wrEntry;

  assign wrEntry = '{valid: wrValid, space: wrSpace, tid: wrTid,
                     size: wrSize, epn: wrEpn};

  vtlb_ctrl u_ctrl (
    .reqValid(reqValid), .reqKind(reqKind), .effAddr(effAddr),
    .instSpace(instSpace), .dataSpace(dataSpace), .procId(procId),
    .srchPid(srchPid), .srchSpace(srchSpace), .wrEn(wrEn),
    .strobes(strobes)
  );

  vtlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .wrEntry(wrEntry), .hit(hit), .hitIdx(hitIdx),
    .multiHit(multiHit), .rspValid(rspValid)
  );
endmodule

// File: tb/tb_vtlb_matcher.sv
module tb_vtlb_matcher;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, instSpace = 0, dataSpace = 0, srchSpace = 0;
  logic [1:0] reqKind = 0;
  logic [31:0] effAddr = 0;
  logic [7:0] procId = 0, srchPid = 0, wrTid = 0;
  logic wrEn = 0, wrValid = 0, wrSpace = 0;
  logic [2:0] wrIdx = 0, wrSize = 0, hitIdx;
  logic [21:0] wrEpn = 0;
  logic hit, multiHit, rspValid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vtlb_matcher dut (.*);

  task automatic check(string tag, logic eRsp, logic eHit, logic [2:0] eIdx, logic eMulti);
    checks++;
    if (rspValid !== eRsp || hit !== eHit || hitIdx !== eIdx || multiHit !== eMulti) begin
      errors++;
      $display("FAIL %s: got rsp=%b hit=%b idx=%0d multi=%b, want rsp=%b hit=%b idx=%0d multi=%b",
               tag, rspValid, hit, hitIdx, multiHit, eRsp, eHit, eIdx, eMulti);
    end
  endtask

  task automatic writeEnt(logic [2:0] idx, logic v, logic [31:0] ea, logic sp, logic [7:0] tid, logic [2:0] sz);
    @(negedge clk);
    wrEn = 1; wrIdx = idx; wrValid = v; wrEpn = ea[31:10]; wrSpace = sp; wrTid = tid; wrSize = sz;
    @(negedge clk);
    wrEn = 0;
  endtask

  // request at negedge; result registered at next posedge, sampled at following negedge
  task automatic look(logic [1:0] kind, logic [31:0] ea, logic is, logic ds, logic [7:0] pid,
                      logic [7:0] sp, logic ss);
    @(negedge clk);
    reqValid = 1; reqKind = kind; effAddr = ea; instSpace = is; dataSpace = ds;
    procId = pid; srchPid = sp; srchSpace = ss;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic testReset();
    check("R1 reset outputs", 0, 0, 0, 0);
    look(0, 32'h0, 0, 0, 0, 0, 0);
    check("R1 lookup after reset misses", 1, 0, 0, 0);
    @(negedge clk);
    check("R2 idle clears response", 0, 0, 0, 0);
  endtask

  task automatic testSources();
    writeEnt(0, 1, 32'h1000_0000, 1, 8'd5, 3'd1);
    look(0, 32'h1000_0ABC, 1, 0, 5, 0, 0);  check("R3 fetch instSpace hit", 1, 1, 0, 0);
    look(0, 32'h1000_0ABC, 0, 1, 5, 0, 0);  check("R3 fetch ignores dataSpace", 1, 0, 0, 0);
    look(0, 32'h1000_0ABC, 1, 0, 6, 0, 0);  check("R3 fetch pid mismatch", 1, 0, 0, 0);
    look(1, 32'h1000_0ABC, 0, 1, 5, 0, 0);  check("R4 data dataSpace hit", 1, 1, 0, 0);
    look(1, 32'h1000_0ABC, 1, 0, 5, 0, 0);  check("R4 data ignores instSpace", 1, 0, 0, 0);
    look(3, 32'h1000_0ABC, 0, 1, 5, 0, 0);  check("R4 kind3 as data", 1, 1, 0, 0);
    look(2, 32'h1000_0ABC, 0, 0, 9, 5, 1);  check("R5 search fields hit", 1, 1, 0, 0);
    look(2, 32'h1000_0ABC, 1, 1, 5, 9, 1);  check("R5 search ignores procId", 1, 0, 0, 0);
    look(2, 32'h1000_0ABC, 1, 1, 5, 5, 0);  check("R5 search ignores state bits", 1, 0, 0, 0);
  endtask

  task automatic testWildAndSize();
    writeEnt(2, 1, 32'h2000_0000, 0, 8'd0, 3'd0);
    look(1, 32'h2000_03FF, 0, 0, 8'd77, 0, 0); check("R6 tid zero any pid", 1, 1, 2, 0);
    look(1, 32'h2000_0400, 0, 0, 8'd77, 0, 0); check("R7 1K boundary miss", 1, 0, 0, 0);
    look(0, 32'h1000_1000, 1, 0, 5, 0, 0);     check("R7 4K boundary miss", 1, 0, 0, 0);
    writeEnt(3, 1, 32'h3000_0000, 0, 8'd7, 3'd7);
    look(1, 32'h3FFF_FFFC, 0, 0, 7, 0, 0);     check("R7 256M top hit", 1, 1, 3, 0);
    look(1, 32'h4000_0000, 0, 0, 7, 0, 0);     check("R7 256M past end miss", 1, 0, 0, 0);
  endtask

  task automatic testMulti();
    writeEnt(5, 1, 32'h3100_0000, 0, 8'd0, 3'd6);
    look(1, 32'h3100_0010, 0, 0, 7, 0, 0);     check("R9 multi lowest index", 1, 1, 3, 1);
    writeEnt(3, 0, 32'h3000_0000, 0, 8'd7, 3'd7);
    look(1, 32'h3100_0010, 0, 0, 7, 0, 0);     check("R8 invalid entry skipped", 1, 1, 5, 0);
    look(1, 32'h3FFF_FFFC, 0, 0, 7, 0, 0);     check("R8 miss index zero", 1, 0, 0, 0);
  endtask

  task automatic testWriteRace();
    @(negedge clk);
    wrEn = 1; wrIdx = 6; wrValid = 1; wrEpn = 22'(32'h5000_0000 >> 10); wrSpace = 1; wrTid = 3; wrSize = 3'd2;
    reqValid = 1; reqKind = 0; effAddr = 32'h5000_0100; instSpace = 1; procId = 3;
    @(negedge clk);
    wrEn = 0;
    check("R10 same-cycle lookup sees old", 1, 0, 0, 0);
    @(negedge clk);
    reqValid = 0;
    check("R10 next-cycle lookup sees new", 1, 1, 6, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSources();
    testWildAndSize();
    testMulti();
    testWriteRace();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule